// File: doc/BRIEF.md
# Programmable Dual Divider with Phase-Frequency Detector

This block forms the digital core of a frequency synthesizer loop. It runs on a single system clock. Two single-cycle strobes mark edges of the reference clock (`ref_tick`) and of the feedback oscillator clock (`fb_tick`). Each strobe stream drives its own 16-bit programmable divider. Each divider emits a one-cycle terminal-count pulse once per programmed number of strobes.

The two divided pulses drive a tri-state phase-frequency detector with dominant reset. A divided reference pulse raises `up`, and a divided feedback pulse raises `dn`. Once both are high they are cleared together. The resulting pulse widths tell an external charge pump which way to steer the tuning signal.

A small write port loads new ratios. A new ratio is held pending and only becomes active when the running period of that divider ends, so a period is never cut short. A 2-bit pump-strength code is registered and passed through, together with its relative weight (1, 4, 20, 80). A lock flag reports a run of consecutive phase-aligned comparisons.

Top module: `tdiv_pfd_top`

## Requirements
- R1: After a synchronous reset, `up`, `dn`, `ref_div`, `fb_div`, `lock` and `pump_code` are 0. Both dividers run with ratio 2, and both have a count of zero.
- R2: The reference divider raises `ref_div` for exactly one clock once every R `ref_tick` strobes. The pulse is visible in the cycle after the clock edge that samples the R-th strobe.
- R3: The feedback divider raises `fb_div` for exactly one clock once every N `fb_tick` strobes, with the same timing as R2.
- R4: A written ratio of 0 or 1 acts as 2. Any ratio from 2 to 65535 is used as written.
- R5: A write with `cfg_we`=1 and `cfg_sel`=0 loads the reference ratio, and `cfg_sel`=1 loads the feedback ratio. The divider finishes its current period with the old ratio, and the new ratio governs the following periods.
- R6: A `ref_div` pulse sets `up` one clock later. `up` stays high until `dn` is also high.
- R7: A `fb_div` pulse sets `dn` one clock later. `dn` stays high until `up` is also high.
- R8: When `up` and `dn` are both high, both are cleared on the next clock. They are never high together for two consecutive cycles.
- R9: A comparison is one cycle with `up` and `dn` both high. It is aligned if neither `up` nor `dn` was high alone since the previous comparison. `lock` rises after 16 consecutive aligned comparisons. A non-aligned comparison clears the run and drops `lock`.
- R10: `pump_code` follows `pump_sel` one clock later. `pump_weight` is 1, 4, 20 or 80 for codes 00, 01, 10 and 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle strobe per reference clock edge |
| fb_tick | input | 1 | One-cycle strobe per feedback clock edge |
| cfg_we | input | 1 | Ratio write strobe |
| cfg_sel | input | 1 | Ratio target: 0 reference, 1 feedback |
| cfg_data | input | 16 | Ratio value |
| pump_sel | input | 2 | Pump-strength code |
| up | output | 1 | Pump-up request |
| dn | output | 1 | Pump-down request |
| ref_div | output | 1 | Reference divider terminal-count pulse |
| fb_div | output | 1 | Feedback divider terminal-count pulse |
| lock | output | 1 | Run of aligned comparisons reached |
| pump_code | output | 2 | Registered pump-strength code |
| pump_weight | output | 7 | Relative pump magnitude for `pump_code` |

## Verification
A divider count or active ratio that is wrong moves the next `ref_div` or `fb_div` pulse away from its expected strobe count. It shows in the first period after the fault, and a premature reload shows within the period that contains the write. A detector state that is stuck or not cleared appears on `up`/`dn` one clock after the divided pulse, or one clock after the overlap cycle. A wrong run counter shows as `lock` rising on the wrong comparison, or failing to drop after a skewed comparison.

// File: rtl/tdiv_pfd_pkg.sv
package tdiv_pfd_pkg;

    localparam int DIV_W     = 16;
    localparam int MIN_RATIO = 2;
    localparam int WEIGHT_W  = 7;

    typedef logic [DIV_W-1:0] ratio_t;

    typedef enum logic {
        TGT_REF = 1'b0,
        TGT_FB  = 1'b1
    } cfg_target_e;

    typedef enum logic [1:0] {
        PUMP_LOW  = 2'b00,
        PUMP_MID  = 2'b01,
        PUMP_HIGH = 2'b10,
        PUMP_MAX  = 2'b11
    } pump_code_e;

    typedef struct packed {
        logic up;
        logic dn;
    } pfd_state_t;

    function automatic ratio_t clamp_ratio(input ratio_t raw);
        if (raw < ratio_t'(MIN_RATIO))
            return ratio_t'(MIN_RATIO);
        return raw;
    endfunction

    function automatic logic [WEIGHT_W-1:0] pump_weight_of(input pump_code_e c);
        case (c)
            PUMP_LOW:  return WEIGHT_W'(1);
            PUMP_MID:  return WEIGHT_W'(4);
            PUMP_HIGH: return WEIGHT_W'(20);
            default:   return WEIGHT_W'(80);
        endcase
    endfunction

endpackage

// File: rtl/tdiv_counter.sv
module tdiv_counter
    import tdiv_pfd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   load_en,
    input  ratio_t load_val,
    output logic   tc_pulse
);

    ratio_t active_q;
    ratio_t pending_q;
    ratio_t cnt_q;
    logic   at_end;

    assign at_end = (cnt_q == active_q - ratio_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q  <= ratio_t'(MIN_RATIO);
            pending_q <= ratio_t'(MIN_RATIO);
            cnt_q     <= '0;
            tc_pulse  <= 1'b0;
        end else begin
            if (load_en)
                pending_q <= clamp_ratio(load_val);
            tc_pulse <= tick && at_end;
            if (tick) begin
                if (at_end) begin
                    cnt_q    <= '0;
                    active_q <= load_en ? clamp_ratio(load_val) : pending_q;
                end else begin
                    cnt_q <= cnt_q + ratio_t'(1);
                end
            end
        end
    end

    // R4: the active ratio never drops under the floor
    a_r4_ratio_floor: assert property (@(posedge clk) disable iff (rst)
        active_q >= ratio_t'(MIN_RATIO));

    // R2: terminal-count pulse lasts a single clock
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        tc_pulse |=> !tc_pulse);

    // R5: the active ratio changes only on a counted terminal tick
    a_r5_reload_at_end: assert property (@(posedge clk) disable iff (rst)
        !(tick && at_end) |=> $stable(active_q));

endmodule

// File: rtl/tdiv_pfd_core.sv
module tdiv_pfd_core
    import tdiv_pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_pulse,
    input  logic       fb_pulse,
    output pfd_state_t st
);

    pfd_state_t st_n;

    always_comb begin
        if (st.up && st.dn) begin
            st_n = '0;
        end else begin
            st_n.up = st.up | ref_pulse;
            st_n.dn = st.dn | fb_pulse;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= st_n;
    end

    // R8: overlap lasts one clock, then both clear
    a_r8_overlap_clears: assert property (@(posedge clk) disable iff (rst)
        (st.up && st.dn) |=> (!st.up && !st.dn));

    // R6: up only rises after a divided reference pulse
    a_r6_up_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(st.up) |-> $past(ref_pulse));

    // R7: dn only rises after a divided feedback pulse
    a_r7_dn_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(st.dn) |-> $past(fb_pulse));

endmodule

// File: rtl/tdiv_lock_mon.sv
module tdiv_lock_mon
    import tdiv_pfd_pkg::*;
#(
    parameter int LOCK_COUNT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  pfd_state_t st,
    output logic       lock
);

    localparam int LW = $clog2(LOCK_COUNT + 1);

    logic [LW-1:0] run_q;
    logic          skew_q;
    logic          overlap;

    assign overlap = st.up && st.dn;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            skew_q <= 1'b0;
        end else if (overlap) begin
            skew_q <= 1'b0;
            if (skew_q)
                run_q <= '0;
            else if (run_q != LW'(LOCK_COUNT))
                run_q <= run_q + LW'(1);
        end else if (st.up ^ st.dn) begin
            skew_q <= 1'b1;
        end
    end

    assign lock = (run_q == LW'(LOCK_COUNT));

    // R9: lock rises only right after a comparison cycle
    a_r9_lock_on_compare: assert property (@(posedge clk) disable iff (rst)
        $rose(lock) |-> $past(overlap));

    // R9: lock never changes outside comparison cycles
    a_r9_lock_steady: assert property (@(posedge clk) disable iff (rst)
        !overlap |=> $stable(lock));

endmodule

// File: rtl/tdiv_pfd_top.sv
module tdiv_pfd_top
    import tdiv_pfd_pkg::*;
#(
    parameter int LOCK_COUNT = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ref_tick,
    input  logic                fb_tick,
    input  logic                cfg_we,
    input  logic                cfg_sel,
    input  logic [DIV_W-1:0]    cfg_data,
    input  logic [1:0]          pump_sel,
    output logic                up,
    output logic                dn,
    output logic                ref_div,
    output logic                fb_div,
    output logic                lock,
    output logic [1:0]          pump_code,
    output logic [WEIGHT_W-1:0] pump_weight
);

    cfg_target_e tgt;
    pfd_state_t  st;
    pump_code_e  code_q;

    assign tgt = cfg_target_e'(cfg_sel);

    tdiv_counter u_ref_div (
        .clk      (clk),
        .rst      (rst),
        .tick     (ref_tick),
        .load_en  (cfg_we && tgt == TGT_REF),
        .load_val (cfg_data),
        .tc_pulse (ref_div)
    );

    tdiv_counter u_fb_div (
        .clk      (clk),
        .rst      (rst),
        .tick     (fb_tick),
        .load_en  (cfg_we && tgt == TGT_FB),
        .load_val (cfg_data),
        .tc_pulse (fb_div)
    );

    tdiv_pfd_core u_pfd (
        .clk       (clk),
        .rst       (rst),
        .ref_pulse (ref_div),
        .fb_pulse  (fb_div),
        .st        (st)
    );

    tdiv_lock_mon #(.LOCK_COUNT(LOCK_COUNT)) u_lock (
        .clk  (clk),
        .rst  (rst),
        .st   (st),
        .lock (lock)
    );

    always_ff @(posedge clk) begin
        if (rst) code_q <= PUMP_LOW;
        else     code_q <= pump_code_e'(pump_sel);
    end

    assign up          = st.up;
    assign dn          = st.dn;
    assign pump_code   = code_q;
    assign pump_weight = pump_weight_of(code_q);

    // R10: weight stays among the four legal magnitudes
    a_r10_weight_legal: assert property (@(posedge clk) disable iff (rst)
        (pump_weight == 7'd1) || (pump_weight == 7'd4) ||
        (pump_weight == 7'd20) || (pump_weight == 7'd80));

endmodule

// File: tb/sim_tdiv_pfd_top.sv
module sim_tdiv_pfd_top;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_tick = 1'b0;
    logic        fb_tick = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [15:0] cfg_data = '0;
    logic [1:0]  pump_sel = '0;
    logic        up, dn, ref_div, fb_div, lock;
    logic [1:0]  pump_code;
    logic [6:0]  pump_weight;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdiv_pfd_top u0 (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .fb_tick(fb_tick),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .pump_sel(pump_sel), .up(up), .dn(dn), .ref_div(ref_div),
        .fb_div(fb_div), .lock(lock), .pump_code(pump_code),
        .pump_weight(pump_weight)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > MAX_CYCLES) begin
            total++; bad++;
            $display("FAIL watchdog: actual cycles=%0d expected <=%0d", cycles, MAX_CYCLES);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic rt, input logic ft);
        ref_tick = rt; fb_tick = ft;
        @(negedge clk);
        ref_tick = 1'b0; fb_tick = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic write_ratio(input logic sel, input int val);
        cfg_we = 1'b1; cfg_sel = sel; cfg_data = 16'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // strobes counted until the divided pulse of the chosen divider appears
    task automatic period(input logic sel, output int n);
        n = 0;
        for (int i = 0; i < 70000; i++) begin
            cyc(!sel, sel);
            n++;
            if ((sel ? fb_div : ref_div) == 1'b1) break;
        end
    endtask

    task automatic aligned_compare();
        cyc(1, 1); cyc(1, 1); cyc(0, 0); cyc(0, 0);
    endtask

    initial begin
        int n;
        @(negedge clk);
        do_reset();

        // R1: reset state
        check("R1 up", up, 0); check("R1 dn", dn, 0);
        check("R1 ref_div", ref_div, 0); check("R1 fb_div", fb_div, 0);
        check("R1 lock", lock, 0); check("R1 pump_code", pump_code, 0);
        period(0, n); check("R1 default ref ratio", n, 2);

        // R2 R3 R4 R5: sweep small ratios on both dividers
        for (int s = 0; s < 2; s++) begin
            for (int r = 0; r < 13; r++) begin
                int exp_r;
                exp_r = (r < 2) ? 2 : r;
                do_reset();
                write_ratio(s[0], r);
                period(s[0], n);
                check(s == 0 ? "R5 old ref period" : "R5 old fb period", n, 2);
                period(s[0], n);
                check(s == 0 ? "R2/R4 ref period" : "R3/R4 fb period", n, exp_r);
                cyc(0, 0);
                check(s == 0 ? "R2 ref pulse width" : "R3 fb pulse width",
                      s == 0 ? ref_div : fb_div, 0);
            end
        end

        // R5: write in mid-period does not shorten or stretch it
        do_reset();
        write_ratio(0, 6);
        period(0, n);
        write_ratio(0, 3);
        cyc(1, 0); cyc(1, 0);
        check("R5 mid-period write kept", ref_div, 0);
        period(0, n); check("R5 rest of old period", n, 4);
        period(0, n); check("R5 new ratio used", n, 3);
        cyc(0, 0);
        check("R5 fb untouched by ref write", fb_div, 0);
        period(1, n); check("R5 fb ratio still default", n, 2);

        // R4: largest ratio
        do_reset();
        write_ratio(1, 65535);
        period(1, n);
        period(1, n); check("R4 max ratio", n, 65535);

        // R6 R8: reference leads
        do_reset();
        cyc(1, 0); cyc(1, 0);
        check("R6 ref_div", ref_div, 1);
        check("R6 up not yet", up, 0);
        cyc(0, 0); check("R6 up set", up, 1); check("R6 dn clear", dn, 0);
        cyc(0, 0); cyc(0, 0); check("R6 up held", up, 1);
        cyc(0, 1); cyc(0, 1); check("R6 up held at fb_div", up, 1);
        cyc(0, 0); check("R8 overlap up", up, 1); check("R8 overlap dn", dn, 1);
        cyc(0, 0); check("R8 cleared up", up, 0); check("R8 cleared dn", dn, 0);

        // R7 R8: feedback leads
        do_reset();
        cyc(0, 1); cyc(0, 1);
        cyc(0, 0); check("R7 dn set", dn, 1); check("R7 up clear", up, 0);
        cyc(0, 0); check("R7 dn held", dn, 1);
        cyc(1, 0); cyc(1, 0);
        cyc(0, 0); check("R8 overlap", {up, dn}, 3);
        cyc(0, 0); check("R8 both cleared", {up, dn}, 0);

        // R8: aligned edges give one shared cycle
        do_reset();
        cyc(1, 1); cyc(1, 1); cyc(0, 0);
        check("R8 aligned overlap", {up, dn}, 3);
        cyc(0, 0); check("R8 aligned clear", {up, dn}, 0);

        // R9: lock run
        do_reset();
        for (int k = 1; k <= 15; k++) aligned_compare();
        check("R9 no lock after 15", lock, 0);
        aligned_compare();
        check("R9 lock after 16", lock, 1);
        aligned_compare();
        check("R9 lock stays", lock, 1);
        cyc(1, 0); cyc(1, 0); cyc(0, 0);
        check("R9 lock kept while skewed", lock, 1);
        cyc(0, 1); cyc(0, 1); cyc(0, 0); cyc(0, 0);
        check("R9 lock dropped", lock, 0);
        for (int k = 1; k <= 15; k++) aligned_compare();
        check("R9 relock not early", lock, 0);
        aligned_compare();
        check("R9 relock", lock, 1);

        // R10: pump code and weight
        for (int c = 0; c < 4; c++) begin
            int w;
            w = (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 20 : 80;
            pump_sel = 2'(c);
            check("R10 code not yet", pump_code, (c == 0) ? 0 : c - 1);
            @(negedge clk);
            check("R10 code", pump_code, c);
            check("R10 weight", pump_weight, w);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule